// File: doc/BRIEF.md
# Raster Sync Generator with Frame-Buffer Read Port

This block drives a VGA-style monitor from one pixel clock. Two counters walk the raster: one counts pixels along a line, the other counts lines. The counters produce horizontal and vertical sync pulses and a display-enable flag. Each axis has its own visible length, front porch, sync width, back porch and sync polarity, and all of them are fixed at compile time. The supplied pixel clock must match the line total times the frame total times the refresh rate.

The block also drives a read address into a linear frame buffer. The frame buffer holds one 24-bit word per pixel, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Pixels are stored one after another in raster order. The address advances only on visible pixels. The memory answers after a fixed number of cycles. The block delays syncs and display enable by that same number of cycles, then registers all of them together with the returned pixel. The result is an aligned sync-plus-RGB stream for an external 8-bit-per-channel video DAC. Defaults target 800x600 at 60 Hz with a 40 MHz clock.

Top module: `vga_raster_scan`

## Requirements
- R1: `hsyncO` is active exactly on line positions h with HA+HF <= h < HA+HF+HW, where HA, HF and HW are the visible, front-porch and sync lengths. The line period is HA+HF+HW+HB cycles.
- R2: The line index advances once per completed line and wraps after VA+VF+VW+VB lines. `vsyncO` is active exactly on lines v with VA+VF <= v < VA+VF+VW.
- R3: Each sync is driven 1 when active if its polarity parameter is 1. It is driven 0 when active if the parameter is 0. The two axes are set independently.
- R4: `deO` is 1 exactly when h < HA and v < VA.
- R5: During a visible pixel, `fbAddr` equals v*HA + h, so it is 0 on the first visible pixel of every frame.
- R6: `fbAddr` does not change during blanking, except for the return to 0 on the last cycle of a frame.
- R7: With a memory of read latency RD_LAT, `hsyncO`, `vsyncO`, `deO` and `rgbO` all describe the same raster position, RD_LAT+1 cycles after `fbAddr` presented it. On visible pixels, `rgbO` equals the memory word at that address.
- R8: `rgbO` is 0 whenever `deO` is 0, whatever the memory returns.
- R9: While `rst` is high at a clock edge, the following hold after that edge: both syncs are at their inactive levels, `deO` is 0, `rgbO` is 0, and `fbAddr` is 0. After release, the scan restarts at line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fbData | input | 24 | Pixel word returned by the frame buffer |
| fbAddr | output | ADDR_W | Frame-buffer read address |
| hsyncO | output | 1 | Horizontal sync, polarity per H_POS_POL |
| vsyncO | output | 1 | Vertical sync, polarity per V_POS_POL |
| deO | output | 1 | Display enable aligned with rgbO |
| rgbO | output | 24 | Pixel data, zero while blanked |

## Verification
The bench runs a small raster with a positive horizontal sync and a negative vertical sync, so a polarity applied to the wrong axis flips one pin at once.

The frame-buffer model returns a nonzero word for every address. A design that forgets to blank would therefore show colour in the porches. A design whose data is one cycle off its syncs would show the neighbouring pixel's word.

Every cycle is compared against a position model. This catches the following faults:
- a counter that wraps one count early or late, which shifts the sync windows;
- an address that keeps counting through the porches, which skews every later line;
- an address that is not cleared at frame end, which runs past the image on the second frame.

A reset in the middle of a frame checks that the outputs go idle and the scan restarts from the origin.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  localparam int PIX_W = 24;

  typedef struct packed {
    logic de;
    logic hsAct;
    logic vsAct;
  } scanStb_t;
endpackage

// File: rtl/vga_scan_ctrl.sv
module vga_scan_ctrl
  import vga_scan_pkg::*;
#(
  parameter int H_ACT = 800,
  parameter int H_FP = 40,
  parameter int H_SW = 128,
  parameter int H_BP = 88,
  parameter int V_ACT = 600,
  parameter int V_FP = 1,
  parameter int V_SW = 4,
  parameter int V_BP = 23,
  parameter int ADDR_W = 19
) (
  input  logic clk,
  input  logic rst,
  output scanStb_t stb,
  output logic [ADDR_W-1:0] fbAddr
);
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int HC_W = $clog2(H_TOT);
  localparam int VC_W = $clog2(V_TOT);
  localparam logic [HC_W-1:0] H_LAST = HC_W'(H_TOT - 1);
  localparam logic [VC_W-1:0] V_LAST = VC_W'(V_TOT - 1);
  localparam logic [HC_W-1:0] H_VIS_END = HC_W'(H_ACT);
  localparam logic [VC_W-1:0] V_VIS_END = VC_W'(V_ACT);
  localparam logic [HC_W-1:0] H_SYNC_BEG = HC_W'(H_ACT + H_FP);
  localparam logic [HC_W-1:0] H_SYNC_END = HC_W'(H_ACT + H_FP + H_SW);
  localparam logic [VC_W-1:0] V_SYNC_BEG = VC_W'(V_ACT + V_FP);
  localparam logic [VC_W-1:0] V_SYNC_END = VC_W'(V_ACT + V_FP + V_SW);

  logic [HC_W-1:0] hCnt;
  logic [VC_W-1:0] vCnt;
  logic hEnd, vEnd, hVis, vVis, visNow;

  assign hEnd = (hCnt == H_LAST);
  assign vEnd = (vCnt == V_LAST);
  assign hVis = (hCnt < H_VIS_END);
  assign vVis = (vCnt < V_VIS_END);
  assign visNow = hVis && vVis;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
      fbAddr <= '0;
    end else begin
      if (hEnd) begin
        hCnt <= '0;
        vCnt <= vEnd ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
      if (hEnd && vEnd) fbAddr <= '0;
      else if (visNow) fbAddr <= fbAddr + 1'b1;
    end
  end

  always_comb begin
    stb.de = visNow;
    stb.hsAct = (hCnt >= H_SYNC_BEG) && (hCnt < H_SYNC_END);
    stb.vsAct = (vCnt >= V_SYNC_BEG) && (vCnt < V_SYNC_END);
  end

  // R1: the visible part and the sync pulse of a line never overlap
  always_comb begin
    if (!rst) assert_h_regions_R1: assert ($onehot0({hVis, stb.hsAct}));
  end

  assert_line_step_R2: assert property (@(posedge clk) disable iff (rst)
    (hCnt != H_LAST) |=> $stable(vCnt));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    visNow |=> (fbAddr == ADDR_W'($past(fbAddr) + 1'b1)));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!visNow && !(hEnd && vEnd)) |=> $stable(fbAddr));
endmodule

// File: rtl/vga_pixel_path.sv
module vga_pixel_path
  import vga_scan_pkg::*;
#(
  parameter int RD_LAT = 1,
  parameter bit H_POS_POL = 1'b1,
  parameter bit V_POS_POL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  scanStb_t stb,
  input  logic [PIX_W-1:0] fbData,
  output logic hsyncO,
  output logic vsyncO,
  output logic deO,
  output logic [PIX_W-1:0] rgbO
);
  scanStb_t pipe [RD_LAT];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else pipe[0] <= stb;
  end

  generate
    for (genvar i = 1; i < RD_LAT; i++) begin : gDelay
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  scanStb_t tail;
  assign tail = pipe[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncO <= !H_POS_POL;
      vsyncO <= !V_POS_POL;
      deO <= 1'b0;
      rgbO <= '0;
    end else begin
      hsyncO <= H_POS_POL ? tail.hsAct : !tail.hsAct;
      vsyncO <= V_POS_POL ? tail.vsAct : !tail.vsAct;
      deO <= tail.de;
      rgbO <= tail.de ? fbData : '0;
    end
  end

  assert_idle_after_reset_R9: assert property (@(posedge clk)
    rst |=> (hsyncO == !H_POS_POL && vsyncO == !V_POS_POL && !deO && rgbO == '0));

  assert_blank_black_R8: assert property (@(posedge clk) disable iff (rst)
    !deO |-> (rgbO == '0));

  // R3: display enable and an active horizontal sync never coincide at the pins
  assert_sync_vs_de_R3: assert property (@(posedge clk) disable iff (rst)
    deO |-> (hsyncO == !H_POS_POL));
endmodule

// File: rtl/vga_raster_scan.sv
module vga_raster_scan
  import vga_scan_pkg::*;
#(
  parameter int H_ACT = 800,
  parameter int H_FP = 40,
  parameter int H_SW = 128,
  parameter int H_BP = 88,
  parameter int V_ACT = 600,
  parameter int V_FP = 1,
  parameter int V_SW = 4,
  parameter int V_BP = 23,
  parameter bit H_POS_POL = 1'b1,
  parameter bit V_POS_POL = 1'b1,
  parameter int RD_LAT = 1,
  localparam int ADDR_W = $clog2(H_ACT * V_ACT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic [23:0] fbData,
  output logic [ADDR_W-1:0] fbAddr,
  output logic hsyncO,
  output logic vsyncO,
  output logic deO,
  output logic [23:0] rgbO
);
  scanStb_t stb;

  vga_scan_ctrl #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk),
    .rst(rst),
    .stb(stb),
    .fbAddr(fbAddr)
  );

  vga_pixel_path #(
    .RD_LAT(RD_LAT), .H_POS_POL(H_POS_POL), .V_POS_POL(V_POS_POL)
  ) uPath (
    .clk(clk),
    .rst(rst),
    .stb(stb),
    .fbData(fbData),
    .hsyncO(hsyncO),
    .vsyncO(vsyncO),
    .deO(deO),
    .rgbO(rgbO)
  );
endmodule

// File: tb/sim_vga_raster_scan.sv
`timescale 1ns/1ps
module sim_vga_raster_scan;
  localparam int HA = 8, HF = 2, HW = 3, HB = 2;
  localparam int VA = 4, VF = 1, VW = 2, VB = 1;
  localparam int HT = HA + HF + HW + HB;
  localparam int VT = VA + VF + VW + VB;
  localparam bit HPOL = 1'b1;
  localparam bit VPOL = 1'b0;
  localparam int AW = $clog2(HA * VA + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] fbData;
  logic [AW-1:0] fbAddr;
  logic hsyncO, vsyncO, deO;
  logic [23:0] rgbO;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  vga_raster_scan #(
    .H_ACT(HA), .H_FP(HF), .H_SW(HW), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VW), .V_BP(VB),
    .H_POS_POL(HPOL), .V_POS_POL(VPOL), .RD_LAT(1)
  ) u0 (
    .clk(clk), .rst(rst), .fbData(fbData), .fbAddr(fbAddr),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .rgbO(rgbO)
  );

  function automatic logic [23:0] pixOf(int a);
    logic [7:0] r, g;
    r = 8'(a + 1);
    g = 8'(a * 3 + 7);
    return {r, g, 8'hC3};
  endfunction

  // frame-buffer model: one-cycle synchronous read, nonzero everywhere
  always_ff @(posedge clk) fbData <= pixOf(int'(fbAddr));

  function automatic int expAddr(int h, int v);
    if (v >= VA) return VA * HA;
    if (h < HA) return v * HA + h;
    return (v + 1) * HA;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkIdle(string tag);
    chk({tag, " hsync idle"}, int'(hsyncO), int'(!HPOL));
    chk({tag, " vsync idle"}, int'(vsyncO), int'(!VPOL));
    chk({tag, " de low"}, int'(deO), 0);
    chk({tag, " rgb zero"}, int'(rgbO), 0);
    chk({tag, " addr zero"}, int'(fbAddr), 0);
  endtask

  // scan cycles after a release at a negedge; n counts posedges since release
  task automatic scanFrames(int frames);
    for (int n = 1; n <= frames * HT * VT; n++) begin
      @(negedge clk);
      begin
        int h = n % HT;
        int v = (n / HT) % VT;
        int p = n - 2;
        if (h < HA && v < VA) chk("R5 addr visible", int'(fbAddr), v * HA + h);
        else chk("R6 addr held in blanking", int'(fbAddr), expAddr(h, v));
        if (p < 0) begin
          chk("R9 output idle after release", int'(deO), 0);
          chk("R9 hsync idle after release", int'(hsyncO), int'(!HPOL));
        end else begin
          int ph = p % HT;
          int pv = (p / HT) % VT;
          bit vis = (ph < HA) && (pv < VA);
          bit hAct = (ph >= HA + HF) && (ph < HA + HF + HW);
          bit vAct = (pv >= VA + VF) && (pv < VA + VF + VW);
          chk("R1/R3 hsync", int'(hsyncO), int'(hAct ? HPOL : !HPOL));
          chk("R2/R3 vsync", int'(vsyncO), int'(vAct ? VPOL : !VPOL));
          chk("R4 de", int'(deO), int'(vis));
          if (vis) chk("R7 rgb pixel", int'(rgbO), int'(pixOf(pv * HA + ph)));
          else chk("R8 rgb blanked", int'(rgbO), 0);
        end
      end
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkIdle("R9 reset");
    rst = 1'b0;
  endtask

  task automatic testFullScan();
    scanFrames(3);
  endtask

  task automatic testMidReset();
    repeat (57) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chkIdle("R9 mid-frame reset");
    @(posedge clk);
    @(negedge clk);
    chkIdle("R9 reset held");
    rst = 1'b0;
    scanFrames(2);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testFullScan();
    testMidReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule